// File: doc/BRIEF.md
# Serial Control Port for a PLL Frequency Synthesizer

This block is the two-wire (I2C) slave that sets up and reports on a PLL frequency synthesizer. The system clock oversamples SCL and SDA. START and STOP are found from SDA edges while SCL is high. The slave address is seven bits. Its two lowest bits come from a strap input, so four synthesizers can share one bus.

In a write transfer the slave accepts any number of data bytes until a STOP. The MSB of the byte that opens a register group picks the group. A 0 selects the two divider bytes, which carry the upper fifteen bits of the 17-bit main divide ratio. A 1 selects the two control bytes. The first control byte carries the two lowest ratio bits, the prescaler enable and the reference code. The second control byte carries the charge-pump current, the clock-output enable and select, and the four open-drain port pull-downs. Divider bits collect in a staging register. The active ratio takes the staged value only when a second control byte completes or when a STOP ends the transfer, so the loop never sees a half-written ratio.

In a read transfer the slave returns a status byte. The byte holds a power-on flag, the loop lock flag, three port input levels and a 3-bit ADC code counted from four comparator outputs. It repeats the byte for as long as the master acknowledges. The power-on flag is set by reset or a brown-out and is cleared when the master ends a read with a not-acknowledge.

Top module: `pll_ctl_i2c`

## Requirements
- R1: The device address is {ADDR_HI, addr_sel_i}, with ADDR_HI defaulting to 5'b11000, and the R/W bit follows as the eighth bit (0 = write). The slave pulls SDA low in the ninth clock only on a match. Any other address is ignored and no output changes.
- R2: A byte in the group-select slot is decoded by its bit 7: 0 means divider-high, 1 means control-1. Divider-high is followed by divider-low, and control-1 is followed by control-2. After divider-low or control-2 the next byte is again in the group-select slot. A write address acknowledge puts the slot back to group-select.
- R3: Byte layouts. Divider-high: bits 6:0 are N[16:10]. Divider-low: bits 7:0 are N[9:2]. Control-1: bits 6:5 are N[1:0], bit 4 is prescale_en_o and bits 3:0 are ref_code_o. Control-2: bits 7:6 are cp_sel_o, bit 5 is clkout_en_o, bit 4 is clkout_sel_o and bits 3:0 are port_pull_o[3:0]. Control fields take effect when their byte is acknowledged.
- R4: div_ratio_o loads the staged ratio only when a control-2 byte is acknowledged or when a STOP follows a transfer that wrote ratio bits. Divider bytes on their own leave it unchanged.
- R5: test_code_o equals control-2 bits 2:0 while clkout_en_o is 0 and clkout_sel_o is 1, and is 0 otherwise.
- R6: In a read the status byte goes out MSB first, and sda_pull_o changes only while SCL is low. A master ACK brings another status byte. A master NACK releases SDA until the next START.
- R7: Status byte layout: bit 7 is the power-on flag, bit 6 is lock_i, bits 5:3 are port_in_i[2:0] and bits 2:0 are the ADC code. It is sampled at the start of each byte.
- R8: The power-on flag is set by reset and while brownout_i is high. It is cleared by a master NACK that ends a read, and an ACKed byte leaves it set.
- R9: The ADC code is the number of set bits in adc_therm_i, giving 0 to 4.
- R10: After reset the divider, all control fields, port_pull_o (all ports high-impedance) and sda_pull_o are 0.
- R11: Every data byte of an addressed write is acknowledged, with no limit on the count before STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 2 | Strapped low address bits |
| lock_i | input | 1 | Loop lock indication |
| brownout_i | input | 1 | Supply low indication |
| port_in_i | input | 3 | Levels of ports 2..0 |
| adc_therm_i | input | 4 | Comparator outputs |
| div_ratio_o | output | 17 | Active main divide ratio |
| prescale_en_o | output | 1 | Divide-by-two prescaler enable |
| ref_code_o | output | 4 | Reference divider code |
| cp_sel_o | output | 2 | Charge-pump current select |
| clkout_en_o | output | 1 | Clock output enable |
| clkout_sel_o | output | 1 | Clock output source / test select |
| test_code_o | output | 3 | Test mode code |
| port_pull_o | output | 4 | Open-drain port pull-downs 3..0 |

## Verification
The bench sends divider bytes on their own, repeats a divider pair without a STOP, and checks the ratio before and after the STOP. A design that commits early would show a half-updated ratio at those points. It opens transfers with a control byte and follows control-2 with a divider byte, which exposes slot sequencing that ignores the selecting MSB. It reads across an ACK and then a NACK, and raises brown-out between reads. A flag cleared on every byte, or never cleared, shows up as a wrong status MSB. Bubbled comparator patterns and a wrong strap address cover ADC encoding and address matching.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
  localparam int ADDR_W     = 7;
  localparam int STRAP_W    = 2;
  localparam int DIV_W      = 17;
  localparam int ADC_LEVELS = 4;
  localparam int ADC_W      = $clog2(ADC_LEVELS + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK
  } eng_state_t;

  typedef enum logic [1:0] {SL_SEL, SL_LO, SL_C2} slot_t;

  typedef struct packed {
    logic       pre_en;
    logic [3:0] ref_code;
    logic [1:0] cp_sel;
    logic       ck_en;
    logic       ck_sel;
    logic [3:0] port_pull;
  } ctrl_t;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_s
);
  localparam int HW = SYNC_STAGES + 1;

  logic [HW-1:0] scl_q, scl_d, sda_q, sda_d;
  logic scl_now, scl_old, sda_old;

  always_comb begin
    scl_d = {scl_q[HW-2:0], scl_i};
    sda_d = {sda_q[HW-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  assign scl_now   = scl_q[HW-2];
  assign scl_old   = scl_q[HW-1];
  assign sda_s     = sda_q[HW-2];
  assign sda_old   = sda_q[HW-1];
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import pll_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [7:0]        status_byte,
  output logic              wr_stb,
  output logic [7:0]        wr_byte,
  output logic              xfer_begin,
  output logic              read_end,
  output logic              sda_pull
);
  eng_state_t st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic       pull_q, pull_d, mack_q, mack_d;

  assign wr_byte  = sh_q;
  assign sda_pull = pull_q;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; pull_d = pull_q; mack_d = mack_q;
    wr_stb = 1'b0; xfer_begin = 1'b0; read_end = 1'b0;
    if (stop_det) begin
      st_d = ST_IDLE; pull_d = 1'b0;
    end else if (start_det) begin
      st_d = ST_ADDR; cnt_d = '0; pull_d = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (st_q == ST_WR) begin
              st_d = ST_WACK; pull_d = 1'b1; wr_stb = 1'b1;
            end else if (sh_q[7:1] == dev_addr) begin
              st_d = ST_AACK; pull_d = 1'b1; xfer_begin = ~sh_q[0];
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          cnt_d = '0;
          if (sh_q[0]) begin
            st_d = ST_RD; sh_d = status_byte; pull_d = ~status_byte[7];
          end else begin
            st_d = ST_WR; pull_d = 1'b0;
          end
        end
        ST_WACK: if (scl_fall) begin
          st_d = ST_WR; cnt_d = '0; pull_d = 1'b0;
        end
        ST_RD: if (scl_fall) begin
          if (cnt_q == 4'd7) begin
            st_d = ST_RACK; pull_d = 1'b0;
          end else begin
            cnt_d  = cnt_q + 4'd1;
            sh_d   = {sh_q[6:0], 1'b0};
            pull_d = ~sh_q[6];
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_d = ~sda_s;
          else if (scl_fall) begin
            if (mack_q) begin
              st_d = ST_RD; cnt_d = '0; sh_d = status_byte; pull_d = ~status_byte[7];
            end else begin
              st_d = ST_IDLE; read_end = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; pull_q <= 1'b0; mack_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d; pull_q <= pull_d; mack_q <= mack_d;
    end
  end
endmodule

// File: rtl/synth_reg_bank.sv
module synth_reg_bank
  import pll_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_begin,
  input  logic             wr_stb,
  input  logic [7:0]       wr_byte,
  input  logic             stop_det,
  output logic [DIV_W-1:0] div_ratio,
  output ctrl_t            ctrl
);
  slot_t            slot_q, slot_d;
  logic [DIV_W-1:0] stage_q, stage_d, div_q, div_d;
  logic             dirty_q, dirty_d, commit;
  ctrl_t            ctrl_q, ctrl_d;

  assign div_ratio = div_q;
  assign ctrl      = ctrl_q;

  always_comb begin
    slot_d = slot_q; stage_d = stage_q; dirty_d = dirty_q; ctrl_d = ctrl_q; commit = 1'b0;
    if (xfer_begin) begin
      slot_d = SL_SEL;
    end else if (wr_stb) begin
      case (slot_q)
        SL_SEL: begin
          dirty_d = 1'b1;
          if (!wr_byte[7]) begin
            stage_d[DIV_W-1:DIV_W-7] = wr_byte[6:0];
            slot_d = SL_LO;
          end else begin
            stage_d[1:0]    = wr_byte[6:5];
            ctrl_d.pre_en   = wr_byte[4];
            ctrl_d.ref_code = wr_byte[3:0];
            slot_d = SL_C2;
          end
        end
        SL_LO: begin
          stage_d[DIV_W-8:2] = wr_byte;
          dirty_d = 1'b1;
          slot_d  = SL_SEL;
        end
        default: begin
          ctrl_d.cp_sel    = wr_byte[7:6];
          ctrl_d.ck_en     = wr_byte[5];
          ctrl_d.ck_sel    = wr_byte[4];
          ctrl_d.port_pull = wr_byte[3:0];
          commit = 1'b1;
          slot_d = SL_SEL;
        end
      endcase
    end else if (stop_det && dirty_q) begin
      commit = 1'b1;
    end
    if (commit) dirty_d = 1'b0;
    div_d = commit ? stage_d : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SL_SEL; stage_q <= '0; div_q <= '0; dirty_q <= 1'b0; ctrl_q <= '0;
    end else begin
      slot_q <= slot_d; stage_q <= stage_d; div_q <= div_d; dirty_q <= dirty_d; ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/therm_count.sv
module therm_count
  import pll_ctl_pkg::*;
(
  input  logic [ADC_LEVELS-1:0] therm,
  output logic [ADC_W-1:0]      code
);
  always_comb begin
    code = '0;
    for (int i = 0; i < ADC_LEVELS; i++) code = code + ADC_W'(therm[i]);
  end
endmodule

// File: rtl/pll_ctl_i2c.sv
module pll_ctl_i2c
  import pll_ctl_pkg::*;
#(
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI     = 5'b11000,
  parameter int                        SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  input  logic [STRAP_W-1:0]    addr_sel_i,
  input  logic                  lock_i,
  input  logic                  brownout_i,
  input  logic [2:0]            port_in_i,
  input  logic [ADC_LEVELS-1:0] adc_therm_i,
  output logic [DIV_W-1:0]      div_ratio_o,
  output logic                  prescale_en_o,
  output logic [3:0]            ref_code_o,
  output logic [1:0]            cp_sel_o,
  output logic                  clkout_en_o,
  output logic                  clkout_sel_o,
  output logic [2:0]            test_code_o,
  output logic [3:0]            port_pull_o
);
  logic [1:0]       rst_ff;
  logic             rst_q_n;
  logic             scl_rise, scl_fall, start_det, stop_det, sda_s;
  logic             wr_stb, xfer_begin, read_end;
  logic [7:0]       wr_byte, status_byte;
  logic [ADC_W-1:0] adc_code;
  logic             por_q, por_d;
  ctrl_t            ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= '0;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_q_n = rst_ff[1];

  i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_q_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_s(sda_s));

  therm_count u_adc (.therm(adc_therm_i), .code(adc_code));

  assign status_byte = {por_q, lock_i, port_in_i, adc_code};

  i2c_bit_engine u_eng (
    .clk(clk), .rst_n(rst_q_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .dev_addr({ADDR_HI, addr_sel_i}), .status_byte(status_byte),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .xfer_begin(xfer_begin),
    .read_end(read_end), .sda_pull(sda_pull_o));

  synth_reg_bank u_regs (
    .clk(clk), .rst_n(rst_q_n), .xfer_begin(xfer_begin), .wr_stb(wr_stb),
    .wr_byte(wr_byte), .stop_det(stop_det), .div_ratio(div_ratio_o), .ctrl(ctrl));

  always_comb begin
    por_d = por_q;
    if (read_end)   por_d = 1'b0;
    if (brownout_i) por_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) por_q <= 1'b1;
    else          por_q <= por_d;
  end

  assign prescale_en_o = ctrl.pre_en;
  assign ref_code_o    = ctrl.ref_code;
  assign cp_sel_o      = ctrl.cp_sel;
  assign clkout_en_o   = ctrl.ck_en;
  assign clkout_sel_o  = ctrl.ck_sel;
  assign port_pull_o   = ctrl.port_pull;
  assign test_code_o   = (!ctrl.ck_en && ctrl.ck_sel) ? ctrl.port_pull[2:0] : 3'b000;
endmodule

// File: rtl/pll_ctl_i2c_chk.sv
module pll_ctl_i2c_chk
  import pll_ctl_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_i,
  input logic                  sda_pull_o,
  input logic [DIV_W-1:0]      div_ratio_o,
  input logic                  wr_stb,
  input logic                  stop_det,
  input logic [2:0]            test_code_o,
  input logic                  clkout_en_o,
  input logic                  clkout_sel_o,
  input logic [ADC_W-1:0]      adc_code,
  input logic [ADC_LEVELS-1:0] adc_therm_i,
  input logic                  por_q,
  input logic                  brownout_i,
  input logic [3:0]            port_pull_o
);
  // R6
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);

  // R4
  div_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_ratio_o) |-> ($past(wr_stb) || $past(stop_det)));

  // R5
  test_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_code_o != 3'b000) |-> (!clkout_en_o && clkout_sel_o));

  // R9
  adc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_code <= ADC_W'(ADC_LEVELS));

  // R9
  adc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_therm_i == '1) |-> (adc_code == ADC_W'(ADC_LEVELS)));

  // R8
  por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_q) |-> !$past(brownout_i));

  // R10
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (port_pull_o == 4'b0000 && !sda_pull_o && div_ratio_o == '0);
    end
  end
endmodule

bind pll_ctl_i2c pll_ctl_i2c_chk u_chk (.*);

// File: tb/sim_pll_ctl_i2c.sv
module sim_pll_ctl_i2c;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'b1100010;

  logic clk = 1'b0;
  logic rst_n, scl, bsda, sda_line, sda_pull;
  logic [1:0] strap;
  logic lock, brown;
  logic [2:0] pin;
  logic [3:0] therm;
  logic [16:0] div;
  logic pre, cken, cksel;
  logic [3:0] refc, pull;
  logic [1:0] cp;
  logic [2:0] tcode;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$], act_q[$];
  string tag_q[$];

  always #10 clk = ~clk;
  assign sda_line = bsda & ~sda_pull;

  pll_ctl_i2c u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .addr_sel_i(strap), .lock_i(lock), .brownout_i(brown), .port_in_i(pin),
    .adc_therm_i(therm), .div_ratio_o(div), .prescale_en_o(pre), .ref_code_o(refc),
    .cp_sel_o(cp), .clkout_en_o(cken), .clkout_sel_o(cksel), .test_code_o(tcode),
    .port_pull_o(pull));

  // driver side: push expected and observed items
  task automatic check(input string tag, input logic [31:0] e, input logic [31:0] a);
    tag_q.push_back(tag); exp_q.push_back(e); act_q.push_back(a);
  endtask

  // monitor side: pop and compare
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0) begin
      logic [31:0] a, e;
      string t;
      a = act_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual=%0h expected=%0h", t, a, e);
      end
    end
  end

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_cyc(input logic b, output logic s);
    bsda = b; wait_q();
    scl = 1'b1; wait_q();
    s = sda_line; wait_q();
    scl = 1'b0; wait_q();
  endtask

  task automatic start_c();
    bsda = 1'b1; wait_q(); scl = 1'b1; wait_q();
    bsda = 1'b0; wait_q(); scl = 1'b0; wait_q();
  endtask

  task automatic stop_c();
    bsda = 1'b0; wait_q(); scl = 1'b1; wait_q(); bsda = 1'b1; wait_q();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cyc(d[i], s);
    bit_cyc(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_cyc(1'b1, s); d[i] = s; end
    bit_cyc(~mack, s);
  endtask

  task automatic wdata(input string tag, input logic [7:0] d);
    logic ack;
    wbyte(d, ack);
    check(tag, 1, ack);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    rst_n = 1'b1; scl = 1'b1; bsda = 1'b1; strap = 2'b10; lock = 1'b0; brown = 1'b0;
    pin = 3'b101; therm = 4'b0000;
    #1 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    check("R10 divider", 0, div);
    check("R10 controls", 0, {pre, refc, cp, cken, cksel, tcode});
    check("R10 ports", 0, pull);
    check("R10 sda", 0, sda_pull);

    // wrong strap bits in address
    start_c(); wbyte({7'b1100011, 1'b0}, ack);
    check("R1 wrong address no ack", 0, ack);
    stop_c();
    check("R1 ignored", 0, {div, pull});

    // full write: div-high, div-low, ctrl1, ctrl2
    start_c(); wbyte({DEV, 1'b0}, ack);
    check("R1 matching address ack", 1, ack);
    wdata("R11 ack hi", 8'h56);
    wdata("R11 ack lo", 8'h8F);
    check("R4 no commit after divider bytes", 0, div);
    wdata("R11 ack c1", 8'hB9);
    check("R3 ctrl1 fields", {1'b1, 4'h9}, {pre, refc});
    wdata("R11 ack c2", 8'hA5);
    check("R4 commit at ctrl2", 17'h15A3D, div);
    check("R3 ctrl2 fields", {2'b10, 1'b1, 1'b0, 4'b0101}, {cp, cken, cksel, pull});
    check("R5 no test mode", 0, tcode);
    stop_c();

    // repeated divider pairs, no commit until STOP
    start_c(); wbyte({DEV, 1'b0}, ack);
    wdata("R2 hi", 8'h01); wdata("R2 lo", 8'h02);
    wdata("R2 hi again", 8'h03); wdata("R2 lo again", 8'h04);
    check("R4 repeated pairs hold ratio", 17'h15A3D, div);
    stop_c(); wait_q();
    check("R4 commit at stop", 17'h00C11, div);

    // control-first transfer then divider byte in next slot
    start_c(); wbyte({DEV, 1'b0}, ack);
    wdata("R2 c1 first", 8'hC3);
    wdata("R2 c2", 8'h56);
    check("R2 commit after control-first", 17'h00C12, div);
    check("R3 ref and prescaler", {1'b0, 4'h3}, {pre, refc});
    check("R5 test code", 3'b110, tcode);
    check("R3 ports in test mode", 4'b0110, pull);
    wdata("R11 extra byte", 8'h7F);
    check("R4 divider byte alone no commit", 17'h00C12, div);
    stop_c(); wait_q();
    check("R2 post-ctrl2 slot decoded as divider", 17'h1FC12, div);

    // reads
    lock = 1'b1; pin = 3'b101; therm = 4'b0111;
    start_c(); wbyte({DEV, 1'b1}, ack);
    check("R1 read address ack", 1, ack);
    rbyte(1'b1, rd);
    check("R7 status with por set", 8'hEB, rd);
    rbyte(1'b0, rd);
    check("R8 por held over ack", 8'hEB, rd);
    check("R6 released after nack", 0, sda_pull);
    stop_c();

    lock = 1'b0; pin = 3'b010; therm = 4'b1111;
    start_c(); wbyte({DEV, 1'b1}, ack);
    rbyte(1'b0, rd);
    check("R8 por cleared, R9 full scale", 8'h14, rd);
    stop_c();

    therm = 4'b0101;
    start_c(); wbyte({DEV, 1'b1}, ack);
    rbyte(1'b0, rd);
    check("R9 bubbled code", 8'h12, rd);
    stop_c();

    brown = 1'b1; repeat (3) @(negedge clk); brown = 1'b0;
    therm = 4'b0000;
    start_c(); wbyte({DEV, 1'b1}, ack);
    rbyte(1'b0, rd);
    check("R8 brownout sets flag, R9 zero", 8'h90, rd);
    stop_c();

    start_c(); wbyte({7'b0100010, 1'b0}, ack);
    check("R1 other prefix ignored", 0, ack);
    stop_c();
    check("R1 outputs kept", 17'h1FC12, div);

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule